// File: doc/BRIEF.md
# Strobed Dual-Register Serial Configuration Port

This block is a serial slave that lets a host program two 18-bit configuration registers over a clock, data and strobe link. It also has a serial output so that several slaves can share one strobe in a chain. All three serial inputs and the write-lock input come from outside the system clock domain. Each one passes through a synchroniser. Edge detectors running on the system clock then turn the serial clock and the strobe into single-cycle events.

While the strobe is low, each rising edge of the serial clock shifts one bit into a 19-bit shift register. The host sends the 18 payload bits first, most significant first, and ends the word with a destination bit. When the strobe rises, the word currently in the shift register is committed. A destination bit of 0 selects the data register and a destination bit of 1 selects the control register. The lock input discards writes to the control register but never blocks writes to the data register. Each register that is actually written raises a one-cycle update flag. Both registers are split into named fields for the motor-drive logic that follows.

The serial output shows the most significant bit of the shift register. It changes only on falling edges of the serial clock, or while the strobe is high. As a result, the word held before a transfer comes out bit by bit during the next transfer.

Top module: `cfg_serial_port`

## Requirements
- R1: A word is 19 bits long. The last bit shifted in (word bit 0) selects the destination: 0 for the data register, 1 for the control register. Word bits 18..1 become register bits 17..0. A commit writes exactly one register.
- R2: Bits shift in only on rising edges of the serial clock while the strobe is low. Serial-clock edges while the strobe is high leave the shift register unchanged.
- R3: A rising edge of the strobe commits the last 19 bits shifted in, however many bits came before them.
- R4: When the lock input is high, a word with bit 0 = 1 is discarded. Data-register writes go ahead whatever the lock level.
- R5: Before the k-th rising serial-clock edge of a transfer (k = 0..18), the serial output shows bit 18-k of the word held in the shift register when the transfer began. The output changes only after a serial-clock falling edge or while the strobe is high.
- R6: After reset, both registers, all field outputs, both update flags and the serial output are 0.
- R7: Data register fields, by word bit: bridge-1 level 6..1, bridge-1 direction 7, bridge-1 slow-decay select 8 (1 = slow, 0 = mixed), bridge-2 level 14..9, bridge-2 direction 15, bridge-2 slow-decay select 16, range select 18..17.
- R8: Control register fields, by word bit: blank select 2..1, off time 7..3, fast-decay time 11..8, clock select 13..12, rectification mode 15..14, spare 17..16, run enable 18 (0 = idle).
- R9: Every register write raises that register's update flag for exactly one system-clock cycle, in the same cycle the new value appears. A discarded write raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Strobe: low to shift, rising edge commits |
| wlock_i | input | 1 | High blocks control-register writes |
| sdo_o | output | 1 | Serial data out for read-back or a chain |
| data_upd_o | output | 1 | One-cycle flag: data register written |
| ctrl_upd_o | output | 1 | One-cycle flag: control register written |
| b1_level_o | output | 6 | Bridge-1 current level |
| b1_dir_o | output | 1 | Bridge-1 direction |
| b1_slow_o | output | 1 | Bridge-1 slow-decay select |
| b2_level_o | output | 6 | Bridge-2 current level |
| b2_dir_o | output | 1 | Bridge-2 direction |
| b2_slow_o | output | 1 | Bridge-2 slow-decay select |
| range_sel_o | output | 2 | Current range select |
| blank_sel_o | output | 2 | Blank time select |
| off_time_o | output | 5 | Fixed off-time code |
| fast_time_o | output | 4 | Fast-decay time code |
| clk_sel_o | output | 2 | Clock source and divider select |
| rect_mode_o | output | 2 | Synchronous rectification mode |
| ctrl_spare_o | output | 2 | Spare control bits |
| run_o | output | 1 | Run enable (0 = idle) |

## Verification
The assertions assume that each serial input holds its level for several system-clock cycles. They also assume that data is stable around every serial-clock rising edge, so that every edge the synchronisers see is a real event and the sampled data bit is the intended one. The stimulus keeps each serial-clock phase at six system-clock cycles. It changes data four cycles before a rising edge and moves the strobe and lock inputs only when the serial clock is low and idle. It sweeps a walking one through every payload bit of both registers, runs a pseudo-random mix of words for both destinations, and covers the locked, over-long and strobe-high cases.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int DAC_W    = 6;
  localparam int RANGE_W  = 2;
  localparam int BLANK_W  = 2;
  localparam int OFF_W    = 5;
  localparam int FAST_W   = 4;
  localparam int CLKSEL_W = 2;
  localparam int RECT_W   = 2;
  localparam int SPARE_W  = 2;

  // Data register layout, most significant field first
  typedef struct packed {
    logic [RANGE_W-1:0] range_sel;
    logic               b2_slow;
    logic               b2_dir;
    logic [DAC_W-1:0]   b2_level;
    logic               b1_slow;
    logic               b1_dir;
    logic [DAC_W-1:0]   b1_level;
  } data_fields_t;

  // Control register layout, most significant field first
  typedef struct packed {
    logic                run;
    logic [SPARE_W-1:0]  spare;
    logic [RECT_W-1:0]   rect_mode;
    logic [CLKSEL_W-1:0] clk_sel;
    logic [FAST_W-1:0]   fast_time;
    logic [OFF_W-1:0]    off_time;
    logic [BLANK_W-1:0]  blank_sel;
  } ctrl_fields_t;

  localparam int PAY_W  = $bits(data_fields_t);
  localparam int WORD_W = PAY_W + 1;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              sdi_i,
  input  logic              out_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    shreg_d = {shreg_q[WORD_W-2:0], sdi_i};
    sdo_d   = shreg_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shift_en_i) begin
      shreg_q <= shreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (out_en_i) begin
      sdo_q <= sdo_d;
    end
  end

  assign word_o = shreg_q;
  assign sdo_o  = sdo_q;

endmodule

// File: rtl/cfg_commit.sv
module cfg_commit #(
  parameter int WORD_W = 19,
  localparam int PAY_W = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              lock_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PAY_W-1:0]  data_q_o,
  output logic [PAY_W-1:0]  ctrl_q_o,
  output logic              data_upd_o,
  output logic              ctrl_upd_o
);

  logic [PAY_W-1:0] data_q, data_d, ctrl_q, ctrl_d;
  logic             dupd_q, dupd_d, cupd_q, cupd_d;
  logic             to_ctrl;

  assign to_ctrl = word_i[0];

  always_comb begin
    data_d = data_q;
    ctrl_d = ctrl_q;
    dupd_d = 1'b0;
    cupd_d = 1'b0;
    if (commit_i) begin
      if (!to_ctrl) begin
        data_d = word_i[WORD_W-1:1];
        dupd_d = 1'b1;
      end else if (!lock_i) begin
        ctrl_d = word_i[WORD_W-1:1];
        cupd_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else if (commit_i) begin
      data_q <= data_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dupd_q <= 1'b0;
      cupd_q <= 1'b0;
    end else begin
      dupd_q <= dupd_d;
      cupd_q <= cupd_d;
    end
  end

  assign data_q_o   = data_q;
  assign ctrl_q_o   = ctrl_q;
  assign data_upd_o = dupd_q;
  assign ctrl_upd_o = cupd_q;

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                sdi_i,
  input  logic                strobe_i,
  input  logic                wlock_i,
  output logic                sdo_o,
  output logic                data_upd_o,
  output logic                ctrl_upd_o,
  output logic [DAC_W-1:0]    b1_level_o,
  output logic                b1_dir_o,
  output logic                b1_slow_o,
  output logic [DAC_W-1:0]    b2_level_o,
  output logic                b2_dir_o,
  output logic                b2_slow_o,
  output logic [RANGE_W-1:0]  range_sel_o,
  output logic [BLANK_W-1:0]  blank_sel_o,
  output logic [OFF_W-1:0]    off_time_o,
  output logic [FAST_W-1:0]   fast_time_o,
  output logic [CLKSEL_W-1:0] clk_sel_o,
  output logic [RECT_W-1:0]   rect_mode_o,
  output logic [SPARE_W-1:0]  ctrl_spare_o,
  output logic                run_o
);

  localparam int IN_W = 4;
  // Input order in the synchroniser: {lock, strobe, data, clock}
  localparam logic [IN_W-1:0] IN_RST = 4'b1100;

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IN_W-1:0] in_lvl;
  logic            sck_lvl, sdi_lvl, str_lvl, wlock_lvl;

  cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i ({wlock_i, strobe_i, sdi_i, sck_i}),
    .level_o (in_lvl)
  );

  assign {wlock_lvl, str_lvl, sdi_lvl, sck_lvl} = in_lvl;

  // Edge detection on serial clock and strobe
  logic sck_prev_q, str_prev_q;
  logic sck_rise, sck_fall, str_rise;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sck_prev_q <= 1'b0;
      str_prev_q <= 1'b1;
    end else begin
      sck_prev_q <= sck_lvl;
      str_prev_q <= str_lvl;
    end
  end

  assign sck_rise = sck_lvl & ~sck_prev_q;
  assign sck_fall = ~sck_lvl & sck_prev_q;
  assign str_rise = str_lvl & ~str_prev_q;

  logic              shift_en, out_en;
  logic [WORD_W-1:0] word;

  assign shift_en = sck_rise & ~str_lvl;
  assign out_en   = sck_fall | str_lvl;

  cfg_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .shift_en_i (shift_en),
    .sdi_i      (sdi_lvl),
    .out_en_i   (out_en),
    .word_o     (word),
    .sdo_o      (sdo_o)
  );

  logic [PAY_W-1:0] data_q, ctrl_q;

  cfg_commit #(.WORD_W(WORD_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .commit_i   (str_rise),
    .lock_i     (wlock_lvl),
    .word_i     (word),
    .data_q_o   (data_q),
    .ctrl_q_o   (ctrl_q),
    .data_upd_o (data_upd_o),
    .ctrl_upd_o (ctrl_upd_o)
  );

  data_fields_t dfld;
  ctrl_fields_t cfld;

  assign dfld = data_fields_t'(data_q);
  assign cfld = ctrl_fields_t'(ctrl_q);

  assign b1_level_o   = dfld.b1_level;
  assign b1_dir_o     = dfld.b1_dir;
  assign b1_slow_o    = dfld.b1_slow;
  assign b2_level_o   = dfld.b2_level;
  assign b2_dir_o     = dfld.b2_dir;
  assign b2_slow_o    = dfld.b2_slow;
  assign range_sel_o  = dfld.range_sel;
  assign blank_sel_o  = cfld.blank_sel;
  assign off_time_o   = cfld.off_time;
  assign fast_time_o  = cfld.fast_time;
  assign clk_sel_o    = cfld.clk_sel;
  assign rect_mode_o  = cfld.rect_mode;
  assign ctrl_spare_o = cfld.spare;
  assign run_o        = cfld.run;

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int WORD_W = 19,
  localparam int PAY_W = WORD_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              str_lvl,
  input logic              str_rise,
  input logic              sck_fall,
  input logic              wlock_lvl,
  input logic [WORD_W-1:0] word,
  input logic [PAY_W-1:0]  data_q,
  input logic [PAY_W-1:0]  ctrl_q,
  input logic              data_upd,
  input logic              ctrl_upd,
  input logic              sdo
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_upd && ctrl_upd)); // R1

  AST_SHIFT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (word != $past(word)) |-> !$past(str_lvl)); // R2

  AST_UPD_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_upd || ctrl_upd) |-> $past(str_rise)); // R3

  AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd |-> !$past(wlock_lvl)); // R4

  AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> ($past(sck_fall) || $past(str_lvl))); // R5

  AST_DATA_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q != $past(data_q)) |-> data_upd); // R9

  AST_CTRL_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> ctrl_upd); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_upd || ctrl_upd) |=> !(data_upd || ctrl_upd)); // R9

endmodule

bind cfg_serial_port cfg_serial_port_chk #(.WORD_W(cfg_port_pkg::WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .str_lvl   (str_lvl),
  .str_rise  (str_rise),
  .sck_fall  (sck_fall),
  .wlock_lvl (wlock_lvl),
  .word      (word),
  .data_q    (data_q),
  .ctrl_q    (ctrl_q),
  .data_upd  (data_upd_o),
  .ctrl_upd  (ctrl_upd_o),
  .sdo       (sdo_o)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, sck, sdi, str_in, wlock;
  logic sdo, data_upd, ctrl_upd;
  logic [5:0] b1_level, b2_level;
  logic b1_dir, b1_slow, b2_dir, b2_slow, run;
  logic [1:0] range_sel, blank_sel, clk_sel, rect_mode, spare;
  logic [4:0] off_time;
  logic [3:0] fast_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .strobe_i(str_in),
    .wlock_i(wlock), .sdo_o(sdo), .data_upd_o(data_upd), .ctrl_upd_o(ctrl_upd),
    .b1_level_o(b1_level), .b1_dir_o(b1_dir), .b1_slow_o(b1_slow),
    .b2_level_o(b2_level), .b2_dir_o(b2_dir), .b2_slow_o(b2_slow),
    .range_sel_o(range_sel), .blank_sel_o(blank_sel), .off_time_o(off_time),
    .fast_time_o(fast_time), .clk_sel_o(clk_sel), .rect_mode_o(rect_mode),
    .ctrl_spare_o(spare), .run_o(run)
  );

  int checks = 0;
  int errors = 0;
  int dcnt = 0, ccnt = 0, exp_dcnt = 0, exp_ccnt = 0;
  bit done = 0;
  logic [18:0] exp_sh = '0;
  logic [17:0] exp_data = '0, exp_ctrl = '0;
  logic [17:0] dut_data, dut_ctrl;

  // Field positions per R7 and R8
  assign dut_data = {range_sel, b2_slow, b2_dir, b2_level, b1_slow, b1_dir, b1_level};
  assign dut_ctrl = {run, spare, rect_mode, clk_sel, fast_time, off_time, blank_sel};

  always @(negedge clk) begin
    if (rst_n) begin
      if (data_upd) dcnt++;
      if (ctrl_upd) ccnt++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic shift_bit(input logic b);
    sdi = b;
    step(4);
    chk(sdo === exp_sh[18], "R5 serial out before rising edge", 32'(sdo), 32'(exp_sh[18]));
    sck = 1'b1;
    step(6);
    sck = 1'b0;
    step(6);
    if (!str_in) exp_sh = {exp_sh[17:0], b};
  endtask

  task automatic check_regs(input string tag);
    chk(dut_data === exp_data, {tag, " data register"}, 32'(dut_data), 32'(exp_data));
    chk(dut_ctrl === exp_ctrl, {tag, " control register"}, 32'(dut_ctrl), 32'(exp_ctrl));
    chk(dcnt == exp_dcnt, "R9 data update pulses", 32'(dcnt), 32'(exp_dcnt));
    chk(ccnt == exp_ccnt, "R9 control update pulses", 32'(ccnt), 32'(exp_ccnt));
  endtask

  task automatic strobe_up(input string tag);
    str_in = 1'b1;
    step(8);
    if (!exp_sh[0]) begin
      exp_data = exp_sh[18:1];
      exp_dcnt++;
    end else if (!wlock) begin
      exp_ctrl = exp_sh[18:1];
      exp_ccnt++;
    end
    check_regs(tag);
  endtask

  task automatic write_word(input logic [18:0] w, input int pre_n, input string tag);
    str_in = 1'b0;
    step(4);
    for (int i = 0; i < pre_n; i++) shift_bit(i[0]);
    for (int i = 18; i >= 0; i--) shift_bit(w[i]);
    step(2);
    strobe_up(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [18:0] w;
    logic [31:0] seed;
    rst_n = 1'b0; sck = 1'b0; sdi = 1'b0; str_in = 1'b1; wlock = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(6);

    // R6 reset state
    chk(dut_data === 18'd0, "R6 data fields after reset", 32'(dut_data), 0);
    chk(dut_ctrl === 18'd0, "R6 control fields after reset", 32'(dut_ctrl), 0);
    chk(sdo === 1'b0, "R6 serial out after reset", 32'(sdo), 0);
    chk({data_upd, ctrl_upd} === 2'b00, "R6 update flags after reset", 32'({data_upd, ctrl_upd}), 0);

    // R7 walking one over the data register
    for (int i = 0; i < 18; i++) begin
      w = {18'(1 << i), 1'b0};
      write_word(w, 0, "R7");
      chk(b2_dir === w[15], "R7 bridge-2 direction bit", 32'(b2_dir), 32'(w[15]));
    end

    // R8 walking one over the control register
    for (int i = 0; i < 18; i++) begin
      w = {18'(1 << i), 1'b1};
      write_word(w, 0, "R8");
      chk(run === w[18], "R8 run enable bit", 32'(run), 32'(w[18]));
      chk(off_time === w[7:3], "R8 off time field", 32'(off_time), 32'(w[7:3]));
    end

    // R4 lock discards control writes, data writes still land
    wlock = 1'b1;
    step(4);
    write_word({18'h2AAAA, 1'b1}, 0, "R4 locked control write");
    write_word({18'h15A5A, 1'b0}, 0, "R4 data write under lock");
    wlock = 1'b0;
    step(4);
    write_word({18'h0F0F3, 1'b1}, 0, "R4 unlocked control write");

    // R3 over-long transfer: only the last 19 bits count
    write_word({18'h3C3C5, 1'b0}, 7, "R3 long data transfer");
    write_word({18'h1234B, 1'b1}, 11, "R3 long control transfer");

    // R2 serial clocks during strobe high do not shift
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    str_in = 1'b0;
    step(6);
    strobe_up("R2 recommit after clocks with strobe high");
    chk(dut_ctrl === 18'h1234B, "R2 control word kept", 32'(dut_ctrl), 32'h1234B);

    // R1 pseudo-random mix of destinations
    seed = 32'h1ACE5;
    for (int i = 0; i < 24; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      w = seed[30:12];
      write_word(w, i % 3, "R1");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule